// File: doc/BRIEF.md
# External Interrupt Request Controller

This block keeps the pending external interrupt requests of one processor together with the mask that enables them. Any agent on the system bus can raise a request by writing to the processor's mapped word. The write does not store its data. It sets exactly one pending bit, and the low bits of the written value choose that bit. Bits are counted from the most significant end, so a value of 0 selects the top bit and a value of `W-1` selects bit 0. A local timer alarm pulse acts like a bus write of 0.

On the processor side, software clears pending bits by writing ones (write-one-to-clear) and loads the whole mask in one write. The block drives a registered level, `irq_hard`. It is high while any pending bit is also enabled in the mask. That level is combined with the interrupt-enable bit of the status word to form the request delivered to the core.

Both bus channels use valid/ready. The block never applies back-pressure: `bus_wr_ready` and `bus_rd_ready` are held at 1, so a beat transfers in any cycle where valid is high. Read responses carry no ready and are issued exactly one cycle after the request.

Top module: `eir_ctrl`

## Requirements
- R1: After reset the request register, the mask register, `irq_hard`, `irq_deliver` and `bus_rd_rsp_valid` are all 0.
- R2: A bus write with all four byte enables set (`bus_wr_be` = 4'b1111) sets request bit `W-1-bus_wr_data[4:0]`. Data 0 sets bit 31 and data 31 sets bit 0. All other request bits keep their values, and data bits above bit 4 have no effect.
- R3: A bus write with any byte enable clear changes no request bit.
- R4: A bus read with `bus_rd_be` = 4'b1111 is answered one cycle later, with `bus_rd_rsp_valid` high and `bus_rd_data` equal to the request register as it stood before the edge that accepted the read. A read with any byte enable clear is answered in the same cycle slot with data 0.
- R5: A processor clear write (`cpu_clr_valid`) clears every request bit that is 1 in `cpu_clr_data` and leaves the other bits unchanged.
- R6: A processor mask write (`cpu_mask_valid`) replaces the whole mask with `cpu_mask_data`.
- R7: `irq_hard` equals the OR-reduction of (request AND mask), taking the register values after the same edge. It therefore changes one cycle after the set, clear or mask write that caused the change.
- R8: A one-cycle `timer_alarm` pulse sets request bit 31, exactly as a full-width bus write of data 0 does.
- R9: When a set, from the bus or the timer, and a processor clear target the same bit in the same cycle, the bit ends up set.
- R10: `irq_deliver` is high exactly when `irq_hard` and `psw_int_en` are both high.
- R11: `bus_wr_ready` and `bus_rd_ready` are always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_valid | input | 1 | Bus write beat valid |
| bus_wr_ready | output | 1 | Bus write ready, always 1 |
| bus_wr_be | input | 4 | Bus write byte enables; only 4'b1111 acts |
| bus_wr_data | input | 32 | Bus write data; low 5 bits select the bit to set |
| bus_rd_valid | input | 1 | Bus read request valid |
| bus_rd_ready | output | 1 | Bus read ready, always 1 |
| bus_rd_be | input | 4 | Bus read byte enables |
| bus_rd_rsp_valid | output | 1 | Read response valid, one cycle after the request |
| bus_rd_data | output | 32 | Read response data |
| cpu_clr_valid | input | 1 | Processor clear write strobe |
| cpu_clr_data | input | 32 | Bits to clear in the request register |
| cpu_mask_valid | input | 1 | Processor mask write strobe |
| cpu_mask_data | input | 32 | New mask value |
| timer_alarm | input | 1 | Timer alarm pulse; sets bit 31 |
| psw_int_en | input | 1 | Interrupt-enable bit of the status word |
| irq_hard | output | 1 | Registered level: a pending bit is enabled |
| irq_deliver | output | 1 | Interrupt presented to the core |

## Verification
Every set, clear and mask write lands on the next clock edge, and `irq_hard` follows on that same edge. The bench therefore drives each operation half a cycle before an edge and compares `irq_hard` against its model on the following falling edge. Read responses are due one edge after the request and reflect the register before that edge. The driver pushes each expected read word into a queue at the moment it issues the read. A falling-edge monitor pops and compares an entry whenever `bus_rd_rsp_valid` is high, and reports a response that arrives with no entry waiting. `irq_deliver` is combinational from `irq_hard` and `psw_int_en`, so it is checked in the same half-cycle as `irq_hard`.

// File: rtl/eir_pkg.sv
package eir_pkg;
  localparam int unsigned EIR_W   = 32;
  localparam int unsigned EIR_BEW = EIR_W / 8;

  function automatic logic all_lanes(input logic [EIR_BEW-1:0] be);
    return &be;
  endfunction
endpackage

// File: rtl/eir_setdec.sv
module eir_setdec #(
  parameter int unsigned W = 32,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic             bus_hit,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic             timer_hit,
  output logic [W-1:0]     set_vec
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    localparam logic [IDX_W-1:0] SEL = IDX_W'(W - 1 - g);
    if (g == W - 1) begin : g_top
      assign set_vec[g] = (bus_hit && (bus_idx == SEL)) || timer_hit;
    end else begin : g_low
      assign set_vec[g] = bus_hit && (bus_idx == SEL);
    end
  end
endmodule

// File: rtl/eir_regs.sv
module eir_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_valid,
  input  logic [W-1:0] clr_data,
  input  logic         mask_valid,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] req_q,
  output logic [W-1:0] mask_q,
  output logic         hard_q
);
  logic [W-1:0] req_n, mask_n, clr_vec;

  always_comb begin
    clr_vec = clr_valid ? clr_data : '0;
    req_n   = (req_q & ~clr_vec) | set_vec;
    mask_n  = mask_valid ? mask_data : mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '0;
      hard_q <= 1'b0;
    end else begin
      req_q  <= req_n;
      mask_q <= mask_n;
      hard_q <= |(req_n & mask_n);
    end
  end
endmodule

// File: rtl/eir_rdport.sv
module eir_rdport #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_fire,
  input  logic         rd_full,
  input  logic [W-1:0] req_q,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_data  <= (rd_fire && rd_full) ? req_q : '0;
    end
  end
endmodule

// File: rtl/eir_ctrl.sv
module eir_ctrl
  import eir_pkg::*;
#(
  parameter int unsigned W = EIR_W,
  localparam int unsigned BEW = W / 8,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr_valid,
  output logic           bus_wr_ready,
  input  logic [BEW-1:0] bus_wr_be,
  input  logic [W-1:0]   bus_wr_data,
  input  logic           bus_rd_valid,
  output logic           bus_rd_ready,
  input  logic [BEW-1:0] bus_rd_be,
  output logic           bus_rd_rsp_valid,
  output logic [W-1:0]   bus_rd_data,
  input  logic           cpu_clr_valid,
  input  logic [W-1:0]   cpu_clr_data,
  input  logic           cpu_mask_valid,
  input  logic [W-1:0]   cpu_mask_data,
  input  logic           timer_alarm,
  input  logic           psw_int_en,
  output logic           irq_hard,
  output logic           irq_deliver
);
  logic [W-1:0] set_vec, req_q, mask_q;
  logic         wr_hit;
  logic         unused_hi_bits;

  assign bus_wr_ready   = 1'b1;
  assign bus_rd_ready   = 1'b1;
  assign wr_hit         = bus_wr_valid && (&bus_wr_be);
  assign unused_hi_bits = ^bus_wr_data[W-1:IDX_W];

  eir_setdec #(.W(W)) u_dec (
    .bus_hit   (wr_hit),
    .bus_idx   (bus_wr_data[IDX_W-1:0]),
    .timer_hit (timer_alarm),
    .set_vec   (set_vec)
  );

  eir_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_valid  (cpu_clr_valid),
    .clr_data   (cpu_clr_data),
    .mask_valid (cpu_mask_valid),
    .mask_data  (cpu_mask_data),
    .req_q      (req_q),
    .mask_q     (mask_q),
    .hard_q     (irq_hard)
  );

  eir_rdport #(.W(W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (bus_rd_valid),
    .rd_full   (&bus_rd_be),
    .req_q     (req_q),
    .rsp_valid (bus_rd_rsp_valid),
    .rsp_data  (bus_rd_data)
  );

  assign irq_deliver = irq_hard && psw_int_en;
endmodule

// File: rtl/eir_ctrl_chk.sv
module eir_ctrl_chk #(
  parameter int unsigned W = 32,
  localparam int unsigned BEW = W / 8,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr_valid,
  input logic [BEW-1:0] bus_wr_be,
  input logic [W-1:0]   bus_wr_data,
  input logic           bus_rd_valid,
  input logic           bus_rd_rsp_valid,
  input logic           cpu_clr_valid,
  input logic [W-1:0]   cpu_clr_data,
  input logic           cpu_mask_valid,
  input logic [W-1:0]   cpu_mask_data,
  input logic           timer_alarm,
  input logic           psw_int_en,
  input logic           irq_hard,
  input logic           irq_deliver,
  input logic           bus_wr_ready,
  input logic           bus_rd_ready,
  input logic [W-1:0]   req_q,
  input logic [W-1:0]   mask_q
);
  logic any_set;
  assign any_set = (bus_wr_valid && (&bus_wr_be)) || timer_alarm;

  AST_BUS_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_valid && (&bus_wr_be)) |=> req_q[W-1-int'($past(bus_wr_data[IDX_W-1:0]))]); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_alarm && cpu_clr_valid) |=> req_q[W-1]); // R9
  AST_TIMER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    timer_alarm |=> req_q[W-1]); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_set |=> ((req_q & ~$past(req_q)) == '0)); // R3
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clr_valid && !any_set) |=> ((req_q & $past(cpu_clr_data)) == '0)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask_valid |=> (mask_q == $past(cpu_mask_data))); // R6
  AST_HARD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hard == (|(req_q & mask_q))); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |=> bus_rd_rsp_valid); // R4
  AST_DELIVER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_deliver == (irq_hard && psw_int_en)); // R10
  AST_NO_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_ready && bus_rd_ready); // R11
endmodule

bind eir_ctrl eir_ctrl_chk #(.W(W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_wr_valid     (bus_wr_valid),
  .bus_wr_be        (bus_wr_be),
  .bus_wr_data      (bus_wr_data),
  .bus_rd_valid     (bus_rd_valid),
  .bus_rd_rsp_valid (bus_rd_rsp_valid),
  .cpu_clr_valid    (cpu_clr_valid),
  .cpu_clr_data     (cpu_clr_data),
  .cpu_mask_valid   (cpu_mask_valid),
  .cpu_mask_data    (cpu_mask_data),
  .timer_alarm      (timer_alarm),
  .psw_int_en       (psw_int_en),
  .irq_hard         (irq_hard),
  .irq_deliver      (irq_deliver),
  .bus_wr_ready     (bus_wr_ready),
  .bus_rd_ready     (bus_rd_ready),
  .req_q            (req_q),
  .mask_q           (mask_q)
);

// File: tb/eir_ctrl_bench.sv
module eir_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_valid = 1'b0, bus_rd_valid = 1'b0;
  logic        bus_wr_ready, bus_rd_ready, bus_rd_rsp_valid;
  logic [3:0]  bus_wr_be = '0, bus_rd_be = '0;
  logic [31:0] bus_wr_data = '0, bus_rd_data;
  logic        cpu_clr_valid = 1'b0, cpu_mask_valid = 1'b0;
  logic [31:0] cpu_clr_data = '0, cpu_mask_data = '0;
  logic        timer_alarm = 1'b0, psw_int_en = 1'b0;
  logic        irq_hard, irq_deliver;

  int total = 0;
  int bad = 0;
  logic [31:0] req_m = '0, mask_m = '0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eir_ctrl u_eir_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: read responses (R4)
  always @(negedge clk) begin
    if (rst_n && bus_rd_rsp_valid) begin
      if (exp_q.size() == 0) check("R4 unexpected response", 32'h1, 32'h0);
      else check("R4 read data", bus_rd_data, exp_q.pop_front());
    end
  end

  // One operation cycle; all inputs sampled at the next rising edge.
  task automatic op(input logic wv, input logic [3:0] wbe, input logic [31:0] wd,
                    input logic cv, input logic [31:0] cd,
                    input logic mv, input logic [31:0] md,
                    input logic tm, input logic rv, input logic [3:0] rbe,
                    input string tag);
    logic [31:0] setv;
    @(negedge clk);
    bus_wr_valid = wv; bus_wr_be = wbe; bus_wr_data = wd;
    cpu_clr_valid = cv; cpu_clr_data = cd;
    cpu_mask_valid = mv; cpu_mask_data = md;
    timer_alarm = tm; bus_rd_valid = rv; bus_rd_be = rbe;
    if (rv) exp_q.push_back((&rbe) ? req_m : 32'h0);
    setv = '0;
    if (wv && (&wbe)) setv[31 - int'(wd[4:0])] = 1'b1;
    if (tm) setv[31] = 1'b1;
    req_m = (req_m & ~(cv ? cd : 32'h0)) | setv;
    if (mv) mask_m = md;
    @(negedge clk);
    bus_wr_valid = 1'b0; cpu_clr_valid = 1'b0; cpu_mask_valid = 1'b0;
    timer_alarm = 1'b0; bus_rd_valid = 1'b0;
    check({"R7 ", tag}, {31'h0, irq_hard}, {31'h0, |(req_m & mask_m)});
    check({"R10 ", tag}, {31'h0, irq_deliver}, {31'h0, irq_hard & psw_int_en});
  endtask

  task automatic rd(input string tag);
    op(0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 irq_hard", {31'h0, irq_hard}, 32'h0);
    check("R1 rsp_valid", {31'h0, bus_rd_rsp_valid}, 32'h0);
    check("R11 ready", {30'h0, bus_wr_ready, bus_rd_ready}, 32'h3);
    rd("R1 req zero");
    // R2: data 0 -> bit 31, data 31 -> bit 0, high data bits ignored
    op(1, 4'hF, 32'h0, 0, 0, 0, 0, 0, 0, 4'h0, "R2 d0");
    op(1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 4'h0, "R2 d31");
    op(1, 4'hF, 32'hABCD_1205, 0, 0, 0, 0, 0, 1, 4'hF, "R2 d5");
    rd("R2 readback");
    // R3: partial byte enables ignored
    op(1, 4'h7, 32'h3, 0, 0, 0, 0, 0, 0, 4'h0, "R3 partial");
    rd("R3 readback");
    // R4: partial read returns zero
    op(0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'h3, "R4 partial rd");
    // R6 + R7: mask enables irq
    op(0, 4'h0, 0, 0, 0, 1, 32'h0400_0000, 0, 0, 4'h0, "R6 mask");
    psw_int_en = 1'b1;
    op(0, 4'h0, 0, 0, 0, 1, 32'h0000_0001, 0, 0, 4'h0, "R6 mask bit0");
    // R10 gate off
    psw_int_en = 1'b0;
    op(0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 4'h0, "R10 gated");
    psw_int_en = 1'b1;
    // R5: W1C clear bit 0 -> irq drops
    op(0, 4'h0, 0, 1, 32'h0000_0001, 0, 0, 0, 1, 4'hF, "R5 clr");
    rd("R5 readback");
    // R8: timer sets bit 31
    op(0, 4'h0, 0, 1, 32'hFFFF_FFFF, 1, 32'h8000_0000, 0, 0, 4'h0, "R5 clr all");
    op(0, 4'h0, 0, 0, 0, 0, 0, 1, 0, 4'h0, "R8 timer");
    rd("R8 readback");
    // R9: set wins over clear of same bit, both sources
    op(1, 4'hF, 32'h7, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 4'h0, "R9 bus vs clr");
    rd("R9 bus readback");
    op(0, 4'h0, 0, 1, 32'h8000_0000, 0, 0, 1, 0, 4'h0, "R9 timer vs clr");
    rd("R9 timer readback");
    // sweep: every index sets its bit
    op(0, 4'h0, 0, 1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 0, 0, 4'h0, "R5 wipe");
    for (int i = 0; i < 32; i++) begin
      op(1, 4'hF, 32'(i), 0, 0, 0, 0, 0, 1, 4'hF, "R2 sweep");
    end
    rd("R2 sweep final");
    repeat (2) @(negedge clk);
    check("R4 queue drained", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule